// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the pixel clock, line sync, frame sync and data-enable strobes that drive a raster LCD panel. It has no bus port of its own. Software programs it through a narrow write port that holds a horizontal timing word, a vertical timing word, a clock/polarity word, a run bit, an interrupt status word and an interrupt enable word. Each axis runs through the same four phases in this order: sync pulse, back porch, active region, front porch. The horizontal axis counts pixel clock periods and the vertical axis counts lines.

Each timing field holds its count minus one. The pixel clock is the input clock divided by twice the divider field plus one. The two sync outputs each have their own polarity inversion. A further bit picks which pixel clock edge launches new output values. The timing words are copied into working copies only when a frame begins, so software may rewrite them at any moment without corrupting the frame on the panel. Two sticky flags record the start of vertical retrace and the first active pixel of a frame. The interrupt line is the OR of the flags that are enabled.

Register addresses on `wr_addr`: 0 control (bit 0 run), 1 horizontal timing, 2 vertical timing, 3 clock/polarity, 4 interrupt status (write 1 to clear), 5 interrupt enable.

Top module: `lcd_timing_gen`

## Requirements
- R1: While the run bit (address 0, bit 0) is 0, `pix_clk` is low, `de` is low and both syncs sit at their inactive level. After the run bit is set, the first launch edge of `pix_clk` begins a frame with both syncs active.
- R2: The `pix_clk` period is 2 × (divider + 1) input clocks, where the divider is bits 9:0 of address 3.
- R3: The horizontal word (address 1) holds active pixels in bits 9:0, sync width in bits 15:10, front porch in bits 23:16 and back porch in bits 31:24. A line is sync, back porch, active, front porch, each lasting its field + 1 pixel clocks.
- R4: The vertical word (address 2) uses the same bit layout, counted in lines. A frame is sync lines, back porch lines, active lines, front porch lines, each lasting its field + 1 lines.
- R5: `de` is high only on pixels that are in the horizontal active phase of a line that is in the vertical active phase.
- R6: Address 3 bit 15 set makes `vsync` active low, and bit 16 set makes `hsync` active low. Clear means active high.
- R7: Address 3 bit 17 selects the launch edge: 0 means outputs change with the rising edge of `pix_clk`, 1 means with the falling edge.
- R8: Status bit 2 is set on the launch edge that begins a frame (the first sync pixel). Status bit 3 is set on the launch edge of the first `de` pixel of a frame.
- R9: `irq` is high while any status bit is set whose enable bit (address 5, same positions) is set. Status bits stay set while they are masked.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: Timing words written while a frame is running take effect only from the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_clk | output | 1 | Pixel clock to the panel |
| hsync | output | 1 | Line sync, polarity programmable |
| vsync | output | 1 | Frame sync, polarity programmable |
| de | output | 1 | Data enable, high on active pixels |
| irq | output | 1 | OR of enabled status flags |

## Verification
The hardest case to reach is a timing word write that lands in the middle of a frame. The effect only shows when the measured line length changes at the frame boundary and not before it. The bench starts a frame, waits a few pixels, rewrites the horizontal word to a longer line, and measures two lines: one in the current frame, which must keep the old length, and one in the next frame, which must have the new length. Another case needs care: a retrace flag that software clears and then sees set again. To reach it, the bench masks the flag, enables it to show that the flag stayed set, clears it, and then checks that `irq` rises on the exact launch edge where the next frame sync begins.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int CNT_W   = 10;
  localparam int SYNC_W  = 6;
  localparam int PORCH_W = 8;
  localparam int DIV_W   = 10;
  localparam int STAT_W  = 4;

  localparam int ACT_LSB   = 0;
  localparam int SYNC_LSB  = ACT_LSB + CNT_W;
  localparam int FRONT_LSB = SYNC_LSB + SYNC_W;
  localparam int BACK_LSB  = FRONT_LSB + PORCH_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
  localparam logic [ADDR_W-1:0] A_VTIM = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;

  localparam int B_FS_INV   = 15;
  localparam int B_LS_INV   = 16;
  localparam int B_EDGE     = 17;
  localparam int IB_RETRACE = 2;
  localparam int IB_ACTIVE  = 3;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] sync_n;
    logic [CNT_W-1:0] back_n;
    logic [CNT_W-1:0] act_n;
    logic [CNT_W-1:0] front_n;
  } axis_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [REG_W-1:0] w);
    axis_cfg_t c;
    c.act_n   = w[ACT_LSB +: CNT_W];
    c.sync_n  = CNT_W'(w[SYNC_LSB +: SYNC_W]);
    c.front_n = CNT_W'(w[FRONT_LSB +: PORCH_W]);
    c.back_n  = CNT_W'(w[BACK_LSB +: PORCH_W]);
    return c;
  endfunction
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              frame_start,
  input  logic [STAT_W-1:0] set_evt,
  output logic              run,
  output axis_cfg_t         hcfg,
  output axis_cfg_t         vcfg,
  output logic [DIV_W-1:0]  div,
  output logic              fs_inv,
  output logic              ls_inv,
  output logic              fall_edge,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] ien
);
  logic              run_q, run_d;
  logic [REG_W-1:0]  htim_q, htim_d, vtim_q, vtim_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              fs_q, fs_d, ls_q, ls_d, fe_q, fe_d;
  logic [STAT_W-1:0] stat_q, stat_d, ien_q, ien_d, clr;
  axis_cfg_t         hsh_q, hsh_d, vsh_q, vsh_d;

  always_comb begin
    run_d  = run_q;
    htim_d = htim_q;
    vtim_d = vtim_q;
    div_d  = div_q;
    fs_d   = fs_q;
    ls_d   = ls_q;
    fe_d   = fe_q;
    ien_d  = ien_q;
    clr    = '0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: run_d  = wr_data[0];
        A_HTIM: htim_d = wr_data;
        A_VTIM: vtim_d = wr_data;
        A_CLK: begin
          div_d = wr_data[DIV_W-1:0];
          fs_d  = wr_data[B_FS_INV];
          ls_d  = wr_data[B_LS_INV];
          fe_d  = wr_data[B_EDGE];
        end
        A_STAT: clr   = wr_data[STAT_W-1:0];
        A_IEN:  ien_d = wr_data[STAT_W-1:0];
        default: ;
      endcase
    end
    // a new event wins over a clear in the same cycle
    stat_d = (stat_q & ~clr) | set_evt;
    hsh_d  = frame_start ? unpack_axis(htim_q) : hsh_q;
    vsh_d  = frame_start ? unpack_axis(vtim_q) : vsh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      htim_q <= '0;
      vtim_q <= '0;
      div_q  <= '0;
      fs_q   <= 1'b0;
      ls_q   <= 1'b0;
      fe_q   <= 1'b0;
      stat_q <= '0;
      ien_q  <= '0;
      hsh_q  <= '0;
      vsh_q  <= '0;
    end else begin
      run_q  <= run_d;
      htim_q <= htim_d;
      vtim_q <= vtim_d;
      div_q  <= div_d;
      fs_q   <= fs_d;
      ls_q   <= ls_d;
      fe_q   <= fe_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
      hsh_q  <= hsh_d;
      vsh_q  <= vsh_d;
    end
  end

  assign run       = run_q;
  assign hcfg      = hsh_q;
  assign vcfg      = vsh_q;
  assign div       = div_q;
  assign fs_inv    = fs_q;
  assign ls_inv    = ls_q;
  assign fall_edge = fe_q;
  assign status    = stat_q;
  assign ien       = ien_q;

  // R11: working timing copies change only at a frame start
  a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(hsh_q) && $stable(vsh_q)));

  // R10: write-one clears the retrace flag when no new event arrives
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT && wr_data[IB_RETRACE] && !set_evt[IB_RETRACE])
      |=> !stat_q[IB_RETRACE]);
endmodule

// File: rtl/lcdt_pixclk.sv
module lcdt_pixclk
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             fall_edge,
  output logic             pix_clk,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic             pclk_q, pclk_d;
  logic             wrap;

  always_comb begin
    wrap   = (dcnt_q >= div);
    dcnt_d = dcnt_q;
    pclk_d = pclk_q;
    if (!run) begin
      dcnt_d = '0;
      pclk_d = 1'b0;
    end else if (wrap) begin
      dcnt_d = '0;
      pclk_d = ~pclk_q;
    end else begin
      dcnt_d = dcnt_q + 1'b1;
    end
  end

  // a tick coincides with the toggle that produces the launch edge
  assign tick = run && wrap && (pclk_q == fall_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      pclk_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign pix_clk = pclk_q;

  // R2: no pixel clock activity while stopped
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pclk_q);

  // R7: a tick always lands on a pixel clock transition
  a_r7_tick_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pclk_q != $past(pclk_q)));
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             enter_act
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             at_lim;

  always_comb begin
    case (ph_q)
      PH_SYNC: lim = cfg.sync_n;
      PH_BACK: lim = cfg.back_n;
      PH_ACT:  lim = cfg.act_n;
      default: lim = cfg.front_n;
    endcase
    at_lim = (cnt_q == lim);
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    if (restart) begin
      ph_d  = PH_SYNC;
      cnt_d = '0;
    end else if (step) begin
      if (at_lim) begin
        ph_d  = phase_e'(ph_q + 2'd1);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase     = ph_q;
  assign cnt       = cnt_q;
  assign last      = step && (ph_q == PH_FRONT) && at_lim;
  assign enter_act = step && (ph_q == PH_BACK) && at_lim;

  // R3 and R4: the counter never passes the length of its phase
  a_r3_cnt_within: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R3 and R4: phases advance one step in the fixed order
  a_r3_phase_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(restart) && ph_q != $past(ph_q)) |-> (ph_q == phase_e'($past(ph_q) + 2'd1)));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        pix_clk,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        irq
);
  logic              rs1_q, rs2_q, rstn_s;
  logic              run, fs_inv, ls_inv, fall_edge, tick;
  logic [DIV_W-1:0]  div;
  axis_cfg_t         hcfg, vcfg;
  logic [STAT_W-1:0] status, ien, set_evt;
  logic              primed_q, primed_d, frame_start;
  phase_e            h_ph, v_ph;
  logic [CNT_W-1:0]  h_cnt, v_cnt;
  logic              h_last, v_last, h_enter_act, v_enter_act;
  logic              hs_on, vs_on, de_on;

  // reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rstn_s = rs2_q;

  lcdt_regs i_regs (
    .clk(clk), .rst_n(rstn_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .set_evt(set_evt), .run(run), .hcfg(hcfg), .vcfg(vcfg),
    .div(div), .fs_inv(fs_inv), .ls_inv(ls_inv), .fall_edge(fall_edge),
    .status(status), .ien(ien)
  );

  lcdt_pixclk i_pclk (
    .clk(clk), .rst_n(rstn_s), .run(run), .div(div), .fall_edge(fall_edge),
    .pix_clk(pix_clk), .tick(tick)
  );

  lcdt_axis i_hax (
    .clk(clk), .rst_n(rstn_s), .restart(frame_start), .step(tick), .cfg(hcfg),
    .phase(h_ph), .cnt(h_cnt), .last(h_last), .enter_act(h_enter_act)
  );

  lcdt_axis i_vax (
    .clk(clk), .rst_n(rstn_s), .restart(frame_start), .step(h_last), .cfg(vcfg),
    .phase(v_ph), .cnt(v_cnt), .last(v_last), .enter_act(v_enter_act)
  );

  // the first tick after run rises primes the engine and starts a frame
  always_comb begin
    primed_d    = run ? (primed_q | tick) : 1'b0;
    frame_start = tick && (!primed_q || v_last);
    set_evt     = '0;
    set_evt[IB_RETRACE] = frame_start;
    set_evt[IB_ACTIVE]  = primed_q && !frame_start && h_enter_act &&
                          (v_ph == PH_ACT) && (v_cnt == '0);
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) primed_q <= 1'b0;
    else         primed_q <= primed_d;
  end

  assign hs_on = primed_q && (h_ph == PH_SYNC);
  assign vs_on = primed_q && (v_ph == PH_SYNC);
  assign de_on = primed_q && (h_ph == PH_ACT) && (v_ph == PH_ACT);

  assign hsync = hs_on ^ ls_inv;
  assign vsync = vs_on ^ fs_inv;
  assign de    = de_on;
  assign irq   = |(status & ien);

  // R5: data enable never overlaps either sync pulse
  a_r5_de_not_sync: assert property (@(posedge clk) disable iff (!rstn_s)
    de_on |-> (!hs_on && !vs_on));

  // R8: the retrace flag rises together with the first pixel of a frame
  a_r8_ss_at_frame: assert property (@(posedge clk) disable iff (!rstn_s)
    $rose(status[IB_RETRACE]) |-> (vs_on && hs_on && h_cnt == '0 && v_cnt == '0));

  // R8: the active flag rises together with an enabled pixel
  a_r8_sa_at_de: assert property (@(posedge clk) disable iff (!rstn_s)
    $rose(status[IB_ACTIVE]) |-> de_on);

  // R4: vertical active phase is entered only at a line end
  a_r4_vact_entry: assert property (@(posedge clk) disable iff (!rstn_s)
    v_enter_act |-> h_last);

  // R1: clearing run stops the strobes on the next cycle
  a_r1_stop: assert property (@(posedge clk) disable iff (!rstn_s)
    !run |=> (!de_on && !pix_clk));
endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
  import lcdt_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pix_clk, hsync, vsync, de, irq;

  int n_tests;
  int n_fail;
  bit done;

  typedef struct packed {
    logic [7:0] hs, hb, ha, hf;
    logic [7:0] vs, vb, va, vf;
    logic [3:0] dv;
    logic       pv, ph, fe;
  } vec_t;

  // field values (count minus one), divider, vsync inv, hsync inv, falling edge
  localparam vec_t VECS [4] = '{
    '{8'd1, 8'd1, 8'd3, 8'd1, 8'd0, 8'd0, 8'd2, 8'd0, 4'd0, 1'b0, 1'b0, 1'b0},
    '{8'd0, 8'd2, 8'd5, 8'd0, 8'd1, 8'd0, 8'd1, 8'd1, 4'd1, 1'b1, 1'b0, 1'b1},
    '{8'd2, 8'd0, 8'd1, 8'd3, 8'd0, 8'd1, 8'd3, 8'd0, 4'd2, 1'b0, 1'b1, 1'b0},
    '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd0, 1'b1, 1'b1, 1'b1}
  };

  localparam int CAP = 600;
  logic cap_hs [CAP];
  logic cap_vs [CAP];
  logic cap_de [CAP];
  logic cap_irq[CAP];
  logic pre_vs;

  lcd_timing_gen i_lcd_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .de(de), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tword(input logic [7:0] s, input logic [7:0] b,
                                        input logic [7:0] a, input logic [7:0] f);
    return (32'(b) << 24) | (32'(f) << 16) | (32'(s[5:0]) << 10) | 32'(a);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // wait for the next launch edge; n returns the input clocks since entry
  task automatic next_px(input logic fe, output int n);
    logic p;
    n = 0;
    p = pix_clk;
    pre_vs = vsync;
    forever begin
      @(negedge clk);
      n++;
      if (p !== pix_clk && pix_clk === ~fe) break;
      p = pix_clk;
      pre_vs = vsync;
    end
  endtask

  // pixels between the next two rising edges of the (active-high) line sync
  task automatic measure_line(input logic fe, input logic inv, output int len);
    int  n;
    logic prev;
    prev = hsync ^ inv;
    forever begin
      next_px(fe, n);
      if ((hsync ^ inv) && !prev) break;
      prev = hsync ^ inv;
    end
    len = 0;
    prev = 1'b1;
    forever begin
      next_px(fe, n);
      len++;
      if ((hsync ^ inv) && !prev) break;
      prev = hsync ^ inv;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  int  n, per, L, F, exp_first_de;
  int  hs_w, line_len, vs_w, frame_len, first_de, de_cnt, first_irq;
  vec_t v;

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;

    // ---- table-driven frames ----
    for (int k = 0; k < 4; k++) begin
      v = VECS[k];
      do_reset();
      wr(A_HTIM, tword(v.hs, v.hb, v.ha, v.hf));
      wr(A_VTIM, tword(v.vs, v.vb, v.va, v.vf));
      wr(A_CLK, (32'(v.fe) << 17) | (32'(v.ph) << 16) | (32'(v.pv) << 15) | 32'(v.dv));
      wr(A_IEN, 32'h8);
      wr(A_CTRL, 32'h1);
      L = (v.hs + 1) + (v.hb + 1) + (v.ha + 1) + (v.hf + 1);
      F = L * ((v.vs + 1) + (v.vb + 1) + (v.va + 1) + (v.vf + 1));
      exp_first_de = ((v.vs + 1) + (v.vb + 1)) * L + (v.hs + 1) + (v.hb + 1);
      per = 0;
      for (int i = 0; i < 2 * F; i++) begin
        next_px(v.fe, n);
        if (i == 0) begin
          chk("R1 first launch edge starts frame", int'((vsync ^ v.pv) && (hsync ^ v.ph)), 1);
          chk("R6 raw sync levels on first pixel", int'({vsync, hsync}), int'({~v.pv, ~v.ph}));
          chk("R7 frame sync inactive before launch edge", int'(pre_vs ^ v.pv), 0);
        end
        if (i == 1) per = n;
        cap_hs[i]  = hsync ^ v.ph;
        cap_vs[i]  = vsync ^ v.pv;
        cap_de[i]  = de;
        cap_irq[i] = irq;
      end
      hs_w = 0; while (cap_hs[hs_w]) hs_w++;
      vs_w = 0; while (cap_vs[vs_w]) vs_w++;
      line_len = 0; frame_len = 0; first_de = -1; first_irq = -1; de_cnt = 0;
      for (int i = 1; i < 2 * F; i++) begin
        if (line_len == 0 && cap_hs[i] && !cap_hs[i-1]) line_len = i;
        if (frame_len == 0 && cap_vs[i] && !cap_vs[i-1]) frame_len = i;
      end
      for (int i = 0; i < 2 * F; i++) begin
        if (first_de < 0 && cap_de[i]) first_de = i;
        if (first_irq < 0 && cap_irq[i]) first_irq = i;
        if (i < F && cap_de[i]) de_cnt++;
      end
      chk("R2 pixel clock period", per, 2 * (v.dv + 1));
      chk("R3 line sync width", hs_w, v.hs + 1);
      chk("R3 line length", line_len, L);
      chk("R4 frame sync width", vs_w, (v.vs + 1) * L);
      chk("R4 frame length", frame_len, F);
      chk("R5 first enabled pixel", first_de, exp_first_de);
      chk("R5 enabled pixels per frame", de_cnt, (v.ha + 1) * (v.va + 1));
      chk("R8 active flag with first enabled pixel", first_irq, exp_first_de);
    end

    // ---- reset state ----
    do_reset();
    chk("R1 reset outputs", int'({pix_clk, hsync, vsync, de, irq}), 0);

    // ---- stop with inverted syncs ----
    wr(A_HTIM, tword(8'd1, 8'd1, 8'd3, 8'd1));
    wr(A_VTIM, tword(8'd0, 8'd0, 8'd2, 8'd0));
    wr(A_CLK, 32'h0001_8000);
    wr(A_CTRL, 32'h1);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    chk("R1 R6 stopped outputs idle", int'({pix_clk, de, hsync, vsync}), 4'b0011);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pix_clk) n++;
    end
    chk("R1 pixel clock held low", n, 0);

    // ---- retrace flag: mask, sticky, clear, re-arm ----
    do_reset();
    wr(A_HTIM, tword(8'd1, 8'd1, 8'd3, 8'd1));
    wr(A_VTIM, tword(8'd0, 8'd0, 8'd2, 8'd0));
    wr(A_IEN, 32'h0);
    wr(A_CTRL, 32'h1);
    next_px(1'b0, n);
    repeat (3) @(negedge clk);
    chk("R9 masked flag keeps irq low", int'(irq), 0);
    wr(A_IEN, 32'h4);
    chk("R9 sticky flag shows once enabled", int'(irq), 1);
    wr(A_STAT, 32'h0);
    chk("R10 writing zero keeps flag", int'(irq), 1);
    wr(A_STAT, 32'h4);
    chk("R10 write one clears flag", int'(irq), 0);
    begin
      logic pv_prev, pirq;
      pv_prev = vsync; pirq = irq;
      forever begin
        next_px(1'b0, n);
        if (vsync && !pv_prev) break;
        pv_prev = vsync; pirq = irq;
      end
      chk("R8 retrace flag low before frame", int'(pirq), 0);
      chk("R8 retrace flag set on frame start", int'(irq), 1);
    end

    // ---- timing word written mid-frame ----
    do_reset();
    wr(A_HTIM, tword(8'd1, 8'd1, 8'd3, 8'd1));
    wr(A_VTIM, tword(8'd0, 8'd0, 8'd2, 8'd0));
    wr(A_CTRL, 32'h1);
    next_px(1'b0, n);
    repeat (3) next_px(1'b0, n);
    wr(A_HTIM, tword(8'd3, 8'd3, 8'd3, 8'd3));
    measure_line(1'b0, 1'b0, line_len);
    chk("R11 current frame keeps old line", line_len, 10);
    begin
      logic pv_prev;
      pv_prev = vsync;
      forever begin
        next_px(1'b0, n);
        if (vsync && !pv_prev) break;
        pv_prev = vsync;
      end
    end
    measure_line(1'b0, 1'b0, line_len);
    chk("R11 next frame uses new line", line_len, 16);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule